// File: doc/BRIEF.md
# Dual-Port Flow-Control Message Scheduler

This block sits beside two receive buffers, a regular one and a priority one, and decides when a flow-control message has to go out to the far end. Each buffer reports its fill level against a threshold. When a level reaches its threshold the block flags a breach for that port and raises a send request. The request stays up until the message path accepts it. Once a message for a port has been sent, a refresh timer runs for that port. If the breach is still there when the timer runs out, the block requests the message again and pulses a retransmit status. When the breach goes away, the timer stops and any unsent request is withdrawn.

Only one message path exists, so a small fixed-priority arbiter picks between the two ports. The priority port always wins a tie.

On the receive side, the block takes decoded flow-control messages. Each message carries an 8-bit pause time and a per-port valid strobe. The pause time loads a countdown for the matching local transmit port, and that port is held off while the countdown is non-zero. If a message arrives while flow control is switched off, it has no effect and an error pulse is raised instead.

Top module: `fc_msg_sched`

## Requirements
- R1: A port's breach status is high in the cycle after its fill level is greater than or equal to its threshold, and low in the cycle after the level is below it (level equal to threshold counts as a breach).
- R2: When a port's breach status rises, a send request for that port appears in the same cycle: `msg_req` is high and `msg_port` names the port (0 = regular, 1 = priority). The request is held until a cycle in which `msg_ready` is high, and it drops in the following cycle.
- R3: Suppose a port's message is accepted at clock edge S and the breach holds without a break. Then at edge S+REFRESH_CYC that port requests again, and its retransmit status is high for exactly that one cycle.
- R4: When a port's fill level falls below its threshold, its timer stops: no further request and no retransmit pulse for that port follows. A request that has not yet been accepted is withdrawn in the same cycle that the breach status drops.
- R5: When both ports are requesting, `msg_port` is 1 (priority). The regular port's request is presented after the priority message has been accepted.
- R6: Breach status, requests, timers and retransmit pulses of the two ports are independent: activity on one port leaves the other port's outputs unchanged.
- R7: With `fc_enable` high, a valid received message for a port loads that port's pause count with `rx_pause`. The port's hold output is then high for exactly `rx_pause` cycles, starting in the next cycle. A new message replaces the remaining count, and a pause time of 0 releases the hold at once.
- R8: A received message while `fc_enable` is low leaves both pause counts untouched. Instead, `fc_unexp_err` is high for one cycle, the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_enable | input | 1 | Flow control switched on |
| reg_level | input | LVL_W | Regular buffer fill level |
| reg_thresh | input | LVL_W | Regular buffer breach threshold |
| pri_level | input | LVL_W | Priority buffer fill level |
| pri_thresh | input | LVL_W | Priority buffer breach threshold |
| msg_ready | input | 1 | Message path accepts the presented request this cycle |
| msg_req | output | 1 | A flow-control message is requested |
| msg_port | output | 1 | Port of the requested message (0 regular, 1 priority) |
| reg_breach | output | 1 | Regular buffer breach status |
| pri_breach | output | 1 | Priority buffer breach status |
| reg_retx | output | 1 | Regular port refresh retransmit pulse |
| pri_retx | output | 1 | Priority port refresh retransmit pulse |
| rx_reg_valid | input | 1 | Received message for the regular port |
| rx_pri_valid | input | 1 | Received message for the priority port |
| rx_pause | input | 8 | Raw pause time carried by the received message |
| reg_tx_hold | output | 1 | Regular transmit port held off |
| pri_tx_hold | output | 1 | Priority transmit port held off |
| fc_unexp_err | output | 1 | Message received while flow control is off |

## Verification
The hardest situation to reach is a refresh expiry: a breach that has to persist across a whole timer period after an accepted send. Only at that point does the retransmit pulse appear. The stimulus holds the regular level at its threshold and keeps `msg_ready` high so that the first message is accepted at a known edge. It then counts REFRESH_CYC cycles and samples the second request and the one-cycle pulse at that exact cycle. A second scenario raises both levels while `msg_ready` is low, so that both ports contend at once. It then releases the path and checks the order in which the ports are served.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam int NPORT    = 2;
  localparam int PORT_REG = 0;
  localparam int PORT_PRI = 1;
  localparam int PAUSE_W  = 8;

  // Breach test: a level at the threshold already counts.
  function automatic logic fill_breached(input logic [31:0] lvl, input logic [31:0] thr);
    return (lvl >= thr);
  endfunction

  // Pause countdown step: a load replaces, otherwise count down to zero.
  function automatic logic [PAUSE_W-1:0] pause_next(input logic load,
                                                    input logic [PAUSE_W-1:0] val,
                                                    input logic [PAUSE_W-1:0] cur);
    if (load)           return val;
    else if (cur != '0) return cur - 1'b1;
    else                return cur;
  endfunction

endpackage

// File: rtl/fcs_port_watch.sv
module fcs_port_watch #(
  parameter int LVL_W       = 8,
  parameter int REFRESH_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  input  logic             grant,
  output logic             breach,
  output logic             pend,
  output logic             retx
);
  localparam int TMR_W = (REFRESH_CYC > 1) ? $clog2(REFRESH_CYC) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REFRESH_CYC - 1);

  logic             cmp;
  logic             rise_ev;
  logic             expire_ev;
  logic             arm_q;
  logic [TMR_W-1:0] tmr_q;

  assign cmp       = fcs_pkg::fill_breached(32'(level), 32'(thresh));
  assign rise_ev   = cmp & ~breach;
  assign expire_ev = arm_q & breach & (tmr_q == TMR_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      breach <= 1'b0;
      pend   <= 1'b0;
      retx   <= 1'b0;
      arm_q  <= 1'b0;
      tmr_q  <= '0;
    end else begin
      breach <= cmp;
      retx   <= expire_ev & cmp;
      pend   <= cmp & (rise_ev | expire_ev | (pend & ~grant));
      if (!cmp) begin
        arm_q <= 1'b0;
        tmr_q <= '0;
      end else if (grant) begin
        arm_q <= 1'b1;
        tmr_q <= '0;
      end else if (expire_ev) begin
        arm_q <= 1'b0;
        tmr_q <= '0;
      end else if (arm_q) begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  AST_RISE_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(breach) |-> pend); // R2
  AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !pend); // R2
  AST_RETX_IN_BREACH: assert property (@(posedge clk) disable iff (!rst_n)
    retx |-> breach); // R3
  AST_RETX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    retx |=> !retx); // R3
  AST_TIMER_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm_q && pend)); // R3

endmodule

// File: rtl/fcs_arbiter.sv
module fcs_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pend,
  input  logic       ready,
  output logic [1:0] grant,
  output logic       req,
  output logic       port
);
  // Fixed priority: index 1 (priority port) wins over index 0.
  assign req      = |pend;
  assign port     = pend[1];
  assign grant[1] = ready & pend[1];
  assign grant[0] = ready & pend[0] & ~pend[1];

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R5
  AST_PRI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == 2'b11 && ready) |-> (grant == 2'b10)); // R5

endmodule

// File: rtl/fcs_pause_ctr.sv
module fcs_pause_ctr (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [fcs_pkg::PAUSE_W-1:0] value,
  output logic                        hold
);
  logic [fcs_pkg::PAUSE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= fcs_pkg::pause_next(load, value, cnt_q);
  end

  assign hold = (cnt_q != '0);

  AST_HOLD_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && value != '0) |=> hold); // R7
  AST_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt_q <= $past(cnt_q))); // R7

endmodule

// File: rtl/fc_msg_sched.sv
module fc_msg_sched #(
  parameter int LVL_W       = 8,
  parameter int REFRESH_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fc_enable,
  input  logic [LVL_W-1:0] reg_level,
  input  logic [LVL_W-1:0] reg_thresh,
  input  logic [LVL_W-1:0] pri_level,
  input  logic [LVL_W-1:0] pri_thresh,
  input  logic             msg_ready,
  output logic             msg_req,
  output logic             msg_port,
  output logic             reg_breach,
  output logic             pri_breach,
  output logic             reg_retx,
  output logic             pri_retx,
  input  logic             rx_reg_valid,
  input  logic             rx_pri_valid,
  input  logic [7:0]       rx_pause,
  output logic             reg_tx_hold,
  output logic             pri_tx_hold,
  output logic             fc_unexp_err
);
  import fcs_pkg::*;

  logic [LVL_W-1:0] lvl_a [NPORT];
  logic [LVL_W-1:0] thr_a [NPORT];
  logic [NPORT-1:0] breach_v, pend_v, retx_v, grant_v, rxv_v, load_v, hold_v;
  logic             unexp_q;

  assign lvl_a[PORT_REG] = reg_level;
  assign lvl_a[PORT_PRI] = pri_level;
  assign thr_a[PORT_REG] = reg_thresh;
  assign thr_a[PORT_PRI] = pri_thresh;
  assign rxv_v[PORT_REG] = rx_reg_valid;
  assign rxv_v[PORT_PRI] = rx_pri_valid;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    fcs_port_watch #(.LVL_W(LVL_W), .REFRESH_CYC(REFRESH_CYC)) u_watch (
      .clk    (clk),
      .rst_n  (rst_n),
      .level  (lvl_a[p]),
      .thresh (thr_a[p]),
      .grant  (grant_v[p]),
      .breach (breach_v[p]),
      .pend   (pend_v[p]),
      .retx   (retx_v[p])
    );

    assign load_v[p] = rxv_v[p] & fc_enable;

    fcs_pause_ctr u_pause (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_v[p]),
      .value (rx_pause),
      .hold  (hold_v[p])
    );
  end

  fcs_arbiter u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend_v),
    .ready (msg_ready),
    .grant (grant_v),
    .req   (msg_req),
    .port  (msg_port)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) unexp_q <= 1'b0;
    else        unexp_q <= ~fc_enable & (|rxv_v);
  end

  assign fc_unexp_err = unexp_q;
  assign reg_breach   = breach_v[PORT_REG];
  assign pri_breach   = breach_v[PORT_PRI];
  assign reg_retx     = retx_v[PORT_REG];
  assign pri_retx     = retx_v[PORT_PRI];
  assign reg_tx_hold  = hold_v[PORT_REG];
  assign pri_tx_hold  = hold_v[PORT_PRI];

  AST_ERR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fc_unexp_err |-> $past(!fc_enable)); // R8
  AST_OFF_NO_HOLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fc_enable && !reg_tx_hold) |=> !reg_tx_hold); // R8

endmodule

// File: tb/fc_msg_sched_bench.sv
module fc_msg_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W      = 8;
  localparam int REF        = 16;

  logic clk = 1'b0;
  logic rst_n, fc_enable, msg_ready, rx_reg_valid, rx_pri_valid;
  logic [LVL_W-1:0] reg_level, reg_thresh, pri_level, pri_thresh;
  logic [7:0] rx_pause;
  logic msg_req, msg_port, reg_breach, pri_breach, reg_retx, pri_retx;
  logic reg_tx_hold, pri_tx_hold, fc_unexp_err;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fc_msg_sched #(.LVL_W(LVL_W), .REFRESH_CYC(REF)) u_fc_msg_sched (
    .clk(clk), .rst_n(rst_n), .fc_enable(fc_enable),
    .reg_level(reg_level), .reg_thresh(reg_thresh),
    .pri_level(pri_level), .pri_thresh(pri_thresh),
    .msg_ready(msg_ready), .msg_req(msg_req), .msg_port(msg_port),
    .reg_breach(reg_breach), .pri_breach(pri_breach),
    .reg_retx(reg_retx), .pri_retx(pri_retx),
    .rx_reg_valid(rx_reg_valid), .rx_pri_valid(rx_pri_valid), .rx_pause(rx_pause),
    .reg_tx_hold(reg_tx_hold), .pri_tx_hold(pri_tx_hold), .fc_unexp_err(fc_unexp_err)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fc_enable = 1'b1; msg_ready = 1'b0;
    rx_reg_valid = 1'b0; rx_pri_valid = 1'b0; rx_pause = '0;
    reg_level = 0; reg_thresh = 100; pri_level = 0; pri_thresh = 50;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 reset breach", {reg_breach, pri_breach}, 0);
    check("R2 reset req", msg_req, 0);
    check("R7 reset hold", {reg_tx_hold, pri_tx_hold}, 0);
    check("R8 reset err", fc_unexp_err, 0);
  endtask

  task automatic t_breach_request();
    reg_level = 99; tick();
    check("R1 below threshold", reg_breach, 0);
    reg_level = 100; tick();
    check("R1 at threshold", reg_breach, 1);
    check("R2 request raised", {msg_req, msg_port}, 2'b10);
    check("R6 priority untouched", {pri_breach, pri_retx}, 0);
    tick();
    check("R2 request held", msg_req, 1);
    msg_ready = 1'b1; tick();
    check("R2 request accepted", msg_req, 0);
  endtask

  task automatic t_refresh();
    int early = 0;
    for (int k = 1; k < REF; k++) begin
      tick();
      if (msg_req || reg_retx) early++;
    end
    check("R3 quiet before expiry", early, 0);
    tick();
    check("R3 re-request at expiry", {msg_req, msg_port, reg_retx}, 3'b101);
    tick();
    check("R3 retx single pulse", {reg_retx, msg_req}, 0);
  endtask

  task automatic t_clear();
    int seen = 0;
    reg_level = 20; tick();
    check("R1 breach drops", reg_breach, 0);
    for (int k = 0; k < REF + 3; k++) begin
      tick();
      if (msg_req || reg_retx) seen++;
    end
    check("R4 timer stopped", seen, 0);
    msg_ready = 1'b0; reg_level = 200; tick();
    check("R4 new request", msg_req, 1);
    reg_level = 10; tick();
    check("R4 request withdrawn", {msg_req, reg_breach}, 0);
  endtask

  task automatic t_both();
    msg_ready = 1'b0; reg_level = 120; pri_level = 50; tick();
    check("R5 both breach", {reg_breach, pri_breach}, 2'b11);
    check("R5 priority first", {msg_req, msg_port}, 2'b11);
    msg_ready = 1'b1; tick();
    check("R5 regular after priority", {msg_req, msg_port}, 2'b10);
    tick();
    check("R5 both served", msg_req, 0);
    pri_level = 0; tick();
    check("R6 regular breach kept", {reg_breach, pri_breach}, 2'b10);
    reg_level = 0; msg_ready = 1'b0; tick();
  endtask

  task automatic t_pause();
    int bad = 0;
    fc_enable = 1'b1;
    rx_pri_valid = 1'b1; rx_pause = 5; tick();
    rx_pri_valid = 1'b0;
    check("R7 hold starts", {pri_tx_hold, reg_tx_hold}, 2'b10);
    for (int k = 2; k <= 5; k++) begin
      tick();
      if (!pri_tx_hold) bad++;
    end
    check("R7 hold lasts", bad, 0);
    tick();
    check("R7 hold ends", pri_tx_hold, 0);
    rx_reg_valid = 1'b1; rx_pause = 10; tick();
    rx_reg_valid = 1'b0;
    tick(); tick();
    rx_reg_valid = 1'b1; rx_pause = 2; tick();
    rx_reg_valid = 1'b0;
    check("R7 reload holds", reg_tx_hold, 1);
    tick();
    check("R7 reload second cycle", reg_tx_hold, 1);
    tick();
    check("R7 reload replaces", reg_tx_hold, 0);
    rx_reg_valid = 1'b1; rx_pause = 7; tick();
    rx_pause = 0; tick();
    rx_reg_valid = 1'b0;
    check("R7 zero releases", reg_tx_hold, 0);
  endtask

  task automatic t_disabled();
    fc_enable = 1'b1; rx_pri_valid = 1'b1; rx_pause = 6; tick();
    rx_pri_valid = 1'b0; fc_enable = 1'b0;
    rx_reg_valid = 1'b1; rx_pri_valid = 1'b1; rx_pause = 200; tick();
    rx_reg_valid = 1'b0; rx_pri_valid = 1'b0;
    check("R8 error pulse", fc_unexp_err, 1);
    check("R8 regular not loaded", reg_tx_hold, 0);
    tick();
    check("R8 error clears", fc_unexp_err, 0);
    tick(); tick(); tick();
    check("R8 priority count untouched", pri_tx_hold, 1);
    tick();
    check("R8 priority ends on time", pri_tx_hold, 0);
    fc_enable = 1'b1;
  endtask

  initial begin
    t_reset();
    t_breach_request();
    t_refresh();
    t_clear();
    t_both();
    t_pause();
    t_disabled();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule